// File: doc/BRIEF.md
# Address Stop Breakpoint Comparator

This block watches two streams of processor traffic, instruction fetches carrying a virtual address and real memory references carrying a physical address and a write flag. It raises a halt request when one of them matches an address chosen by an operator. A two-bit mode picks the kind of match. The modes are a fetch from exactly that virtual address, any real reference to exactly that address, a real write to exactly that address, or any real reference that falls anywhere in the 512-word page holding that address.

The halt request is registered and sticky. Once it is raised, the block keeps a record of the triggering access for the operator display: the address, the write flag and the mode. In fetch mode the recorded address is the instruction's address, so the display can show the instruction stored there. A one-cycle clear pulse releases the halt. While the halt is held, later matches are not recorded.

Top module: `brk_match_top`

## Requirements
- R1: After reset, halt_o is 0 and rec_addr_o, rec_write_o and rec_mode_o are all 0.
- R2: With mode_i = 2'b00, a cycle with fetch_valid_i high and fetch_addr_i equal to sel_addr_i causes a halt. Real references are ignored in this mode.
- R3: With mode_i = 2'b01, a cycle with ref_valid_i high and ref_addr_i equal to sel_addr_i causes a halt, whether ref_write_i is 0 (read) or 1 (write).
- R4: With mode_i = 2'b10, only a matching real reference with ref_write_i = 1 causes a halt. A matching read has no effect.
- R5: With mode_i = 2'b11, a real reference causes a halt when ref_addr_i and sel_addr_i agree in bits 9 and up, whatever bits 8..0 hold. A reference that differs in bit 9 or higher has no effect.
- R6: While enable_i is 0, no match raises halt_o.
- R7: halt_o stays 1 until clear_i is pulsed. While halt_o is 1, the record does not change.
- R8: On a halt, the record holds the matching address, the write flag and the mode of the triggering cycle. In mode 2'b00 the recorded address equals sel_addr_i and the recorded write flag is 0.
- R9: In a cycle with clear_i high, halt_o falls at the next edge. A match in that same cycle is discarded.
- R10: halt_o and the record update at the first clock edge after the matching cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Arms the address stop |
| mode_i | input | 2 | Stop mode: 00 fetch, 01 any real ref, 10 real write, 11 page |
| sel_addr_i | input | AW | Operator-selected address |
| fetch_valid_i | input | 1 | Instruction fetch strobe |
| fetch_addr_i | input | AW | Virtual address of the fetch |
| ref_valid_i | input | 1 | Real memory reference strobe |
| ref_addr_i | input | AW | Real address of the reference |
| ref_write_i | input | 1 | 1 = write, 0 = read |
| clear_i | input | 1 | Releases the halt |
| halt_o | output | 1 | Sticky halt request |
| rec_addr_o | output | AW | Recorded matching address |
| rec_write_o | output | 1 | Recorded write flag |
| rec_mode_o | output | 2 | Recorded mode |

## Verification
A clear pulse and a new match can fall in the same cycle. The bench provokes this by driving clear_i high while a matching fetch or reference is on the inputs. It judges the result by checking that halt_o drops at the next edge and stays low, and that the record keeps its old value. A second collision arises when a fetch and a real reference arrive in the same cycle and only one of them fits the mode. The bench drives both together in every mode and checks that the recorded address comes from the stream the mode selects.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    STOP_FETCH   = 2'b00,
    STOP_REF_ANY = 2'b01,
    STOP_REF_WR  = 2'b10,
    STOP_PAGE    = 2'b11
  } stop_mode_e;
endpackage

// File: rtl/brk_cmp.sv
module brk_cmp #(
  parameter int AW        = 16,
  parameter int PAGE_BITS = 9,
  parameter bit PAGE_MODE = 1'b0
) (
  input  logic [AW-1:0] a_i,
  input  logic [AW-1:0] b_i,
  output logic          eq_o
);
  localparam logic [AW-1:0] ALL_ONES = {AW{1'b1}};
  logic [AW-1:0] mask;

  generate
    if (PAGE_MODE) begin : g_page
      assign mask = ALL_ONES << PAGE_BITS;
    end else begin : g_full
      assign mask = ALL_ONES;
    end
  endgenerate

  assign eq_o = ((a_i ^ b_i) & mask) == '0;
endmodule

// File: rtl/brk_sel.sv
module brk_sel
  import brk_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [1:0]    mode_i,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          ref_valid_i,
  input  logic [AW-1:0] ref_addr_i,
  input  logic          ref_write_i,
  input  logic          eq_fetch_i,
  input  logic          eq_ref_i,
  input  logic          eq_page_i,
  output logic          hit_o,
  output logic [AW-1:0] hit_addr_o,
  output logic          hit_write_o
);
  stop_mode_e mode;
  assign mode = stop_mode_e'(mode_i);

  always_comb begin
    hit_o       = 1'b0;
    hit_addr_o  = ref_addr_i;
    hit_write_o = ref_write_i;
    unique case (mode)
      STOP_FETCH: begin
        hit_o       = fetch_valid_i && eq_fetch_i;
        hit_addr_o  = fetch_addr_i;
        hit_write_o = 1'b0;
      end
      STOP_REF_ANY: hit_o = ref_valid_i && eq_ref_i;
      STOP_REF_WR:  hit_o = ref_valid_i && ref_write_i && eq_ref_i;
      STOP_PAGE:    hit_o = ref_valid_i && eq_page_i;
      default:      hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/brk_hold.sv
module brk_hold #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          clear_i,
  input  logic          hit_i,
  input  logic [AW-1:0] hit_addr_i,
  input  logic          hit_write_i,
  input  logic [1:0]    mode_i,
  output logic          halt_o,
  output logic [AW-1:0] rec_addr_o,
  output logic          rec_write_o,
  output logic [1:0]    rec_mode_o
);
  logic capture;
  // clear wins over a coincident hit; a held halt blocks new captures
  assign capture = enable_i && hit_i && !halt_o && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_o      <= 1'b0;
      rec_addr_o  <= '0;
      rec_write_o <= 1'b0;
      rec_mode_o  <= 2'b00;
    end else begin
      if (clear_i) halt_o <= 1'b0;
      else if (capture) halt_o <= 1'b1;
      if (capture) begin
        rec_addr_o  <= hit_addr_i;
        rec_write_o <= hit_write_i;
        rec_mode_o  <= mode_i;
      end
    end
  end
endmodule

// File: rtl/brk_match_top.sv
module brk_match_top #(
  parameter int AW        = 16,
  parameter int PAGE_BITS = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] sel_addr_i,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          ref_valid_i,
  input  logic [AW-1:0] ref_addr_i,
  input  logic          ref_write_i,
  input  logic          clear_i,
  output logic          halt_o,
  output logic [AW-1:0] rec_addr_o,
  output logic          rec_write_o,
  output logic [1:0]    rec_mode_o
);
  logic          eq_fetch, eq_ref, eq_page, hit, hit_write;
  logic [AW-1:0] hit_addr;

  brk_cmp #(.AW(AW), .PAGE_BITS(PAGE_BITS), .PAGE_MODE(1'b0)) u_cmp_fetch (
    .a_i(fetch_addr_i), .b_i(sel_addr_i), .eq_o(eq_fetch));
  brk_cmp #(.AW(AW), .PAGE_BITS(PAGE_BITS), .PAGE_MODE(1'b0)) u_cmp_ref (
    .a_i(ref_addr_i), .b_i(sel_addr_i), .eq_o(eq_ref));
  brk_cmp #(.AW(AW), .PAGE_BITS(PAGE_BITS), .PAGE_MODE(1'b1)) u_cmp_page (
    .a_i(ref_addr_i), .b_i(sel_addr_i), .eq_o(eq_page));

  brk_sel #(.AW(AW)) u_sel (
    .mode_i(mode_i), .fetch_valid_i(fetch_valid_i), .fetch_addr_i(fetch_addr_i),
    .ref_valid_i(ref_valid_i), .ref_addr_i(ref_addr_i), .ref_write_i(ref_write_i),
    .eq_fetch_i(eq_fetch), .eq_ref_i(eq_ref), .eq_page_i(eq_page),
    .hit_o(hit), .hit_addr_o(hit_addr), .hit_write_o(hit_write));

  brk_hold #(.AW(AW)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .clear_i(clear_i),
    .hit_i(hit), .hit_addr_i(hit_addr), .hit_write_i(hit_write), .mode_i(mode_i),
    .halt_o(halt_o), .rec_addr_o(rec_addr_o), .rec_write_o(rec_write_o),
    .rec_mode_o(rec_mode_o));
endmodule

// File: rtl/brk_match_chk.sv
module brk_match_chk #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          enable_i,
  input logic [1:0]    mode_i,
  input logic [AW-1:0] sel_addr_i,
  input logic          clear_i,
  input logic          halt_o,
  input logic [AW-1:0] rec_addr_o,
  input logic          rec_write_o,
  input logic [1:0]    rec_mode_o
);
  assert_clear_drops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !halt_o);

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !clear_i) |=> halt_o);

  assert_record_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> ($stable(rec_addr_o) && $stable(rec_write_o) && $stable(rec_mode_o)));

  assert_disabled_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !halt_o) |=> !halt_o);

  assert_mode_recorded_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> (rec_mode_o == $past(mode_i)));

  assert_fetch_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(halt_o) && rec_mode_o == 2'b00) |-> (rec_addr_o == $past(sel_addr_i) && !rec_write_o));

  assert_write_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(halt_o) && rec_mode_o == 2'b10) |-> rec_write_o);

  assert_exact_ref_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(halt_o) && rec_mode_o == 2'b01) |-> (rec_addr_o == $past(sel_addr_i)));
endmodule

bind brk_match_top brk_match_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .mode_i(mode_i),
  .sel_addr_i(sel_addr_i), .clear_i(clear_i), .halt_o(halt_o),
  .rec_addr_o(rec_addr_o), .rec_write_o(rec_write_o), .rec_mode_o(rec_mode_o));

// File: tb/sim_brk_match_top.sv
module sim_brk_match_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [AW-1:0] sel = '0;
  logic          fv = 1'b0, rv = 1'b0, rw = 1'b0, clr = 1'b0;
  logic [AW-1:0] fa = '0, ra = '0;
  logic          halt, rec_w;
  logic [AW-1:0] rec_a;
  logic [1:0]    rec_m;

  int compared = 0, mismatched = 0, cycles = 0;
  string phase = "R1";

  int m_halt = 0, m_addr = 0, m_wr = 0, m_mode = 0;

  always #10 clk = ~clk;

  brk_match_top #(.AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .mode_i(mode), .sel_addr_i(sel),
    .fetch_valid_i(fv), .fetch_addr_i(fa), .ref_valid_i(rv), .ref_addr_i(ra),
    .ref_write_i(rw), .clear_i(clr), .halt_o(halt), .rec_addr_o(rec_a),
    .rec_write_o(rec_w), .rec_mode_o(rec_m));

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_halt = 0; m_addr = 0; m_wr = 0; m_mode = 0;
    end else if (clr) begin
      m_halt = 0;
    end else if (m_halt == 0 && en) begin
      int hit, a, w;
      hit = 0; a = 0; w = 0;
      if (mode == 0 && fv && fa == sel) begin hit = 1; a = fa; w = 0; end
      if (mode == 1 && rv && ra == sel) begin hit = 1; a = ra; w = rw; end
      if (mode == 2 && rv && rw && ra == sel) begin hit = 1; a = ra; w = 1; end
      if (mode == 3 && rv && (ra / 512) == (sel / 512)) begin hit = 1; a = ra; w = rw; end
      if (hit != 0) begin m_halt = 1; m_addr = a; m_wr = w; m_mode = mode; end
    end
  end

  task automatic chk(string what, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0h expected %0h", phase, what, got, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    cycles++;
    chk("halt", int'(halt), m_halt);
    chk("rec_addr", int'(rec_a), m_addr);
    chk("rec_write", int'(rec_w), m_wr);
    chk("rec_mode", int'(rec_m), m_mode);
  endtask

  task automatic idle();
    fv = 0; rv = 0; rw = 0; clr = 0;
  endtask

  task automatic pulse_clear();
    idle(); clr = 1; cyc(); clr = 0; cyc();
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    phase = "R1";
    repeat (2) cyc();
    rst_n = 1'b1;
    cyc();
    chk("reset halt R1", int'(halt), 0);
    chk("reset addr R1", int'(rec_a), 0);

    en = 1; sel = 16'h1234;
    phase = "R2"; mode = 2'b00;
    rv = 1; ra = 16'h1234; cyc();             // real ref ignored in fetch mode
    idle(); fv = 1; fa = 16'h1235; cyc();     // no match
    fa = 16'h1234; rv = 1; ra = 16'h0042; cyc();
    idle(); cyc();
    phase = "R10"; chk("halt one edge after match R10", int'(halt), 1);
    phase = "R8"; chk("fetch record addr R8", int'(rec_a), 'h1234);

    phase = "R7";
    mode = 2'b01; rv = 1; ra = 16'h1234; rw = 1; cyc();
    fv = 1; fa = 16'h1234; cyc();
    idle(); cyc();
    chk("record frozen R7", int'(rec_m), 0);
    pulse_clear();

    phase = "R9";
    mode = 2'b00; fv = 1; fa = 16'h1234; clr = 1; cyc();
    idle(); cyc(); cyc();
    chk("clear beats match R9", int'(halt), 0);

    phase = "R3";
    mode = 2'b01; rv = 1; ra = 16'h1234; rw = 0; fv = 1; fa = 16'h0777; cyc();
    idle(); cyc(); pulse_clear();
    rv = 1; ra = 16'h1234; rw = 1; cyc();
    idle(); cyc();
    chk("any ref write R3", int'(rec_w), 1);
    pulse_clear();

    phase = "R4";
    mode = 2'b10; rv = 1; ra = 16'h1234; rw = 0; cyc();
    idle(); cyc();
    chk("read ignored R4", int'(halt), 0);
    rv = 1; ra = 16'h1234; rw = 1; cyc();
    idle(); cyc(); pulse_clear();

    phase = "R5";
    mode = 2'b11; rv = 1; ra = 16'h1434; rw = 0; cyc();   // other page
    ra = 16'h1200; cyc();
    idle(); cyc();
    chk("page hit addr R5", int'(rec_a), 'h1200);
    pulse_clear();
    rv = 1; ra = 16'h13FF; rw = 1; cyc();
    idle(); cyc(); pulse_clear();

    phase = "R6";
    en = 0;
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m); fv = 1; fa = sel; rv = 1; ra = sel; rw = 1; cyc();
    end
    idle(); cyc();
    chk("disabled no halt R6", int'(halt), 0);
    en = 1;

    phase = "R8";
    for (int i = 0; i < 3000; i++) begin
      mode = 2'($urandom_range(0, 3));
      en   = ($urandom_range(0, 7) != 0);
      fv   = $urandom_range(0, 1); rv = $urandom_range(0, 1); rw = $urandom_range(0, 1);
      fa   = sel ^ AW'($urandom_range(0, 3));
      ra   = sel ^ AW'($urandom_range(0, 3) << $urandom_range(0, 10));
      clr  = ($urandom_range(0, 5) == 0);
      cyc();
    end
    idle(); cyc();
    finish_up();
  end
endmodule